// File: doc/BRIEF.md
# Dual-Channel Phase-Frequency Detector with Lock Indication

This block holds two digital phase-frequency detector channels. Both run on one oscillator clock. Each channel takes a single-cycle reference strobe and a single-cycle feedback strobe. It keeps one flip-flop that records a pending reference edge and one that records a pending feedback edge. When both are set, the comparison is over: both flip-flops clear and the next comparison starts. From these flip-flops the channel builds a two-bit charge-pump command: off (high impedance), source, sink, or balanced. A per-channel sense bit decides whether a leading reference sources or sinks. A coincident pair of strobes still produces one balanced cycle. This keeps the pump from having a dead zone around zero phase error.

Each channel also measures the width of its phase error. The width is the number of oscillator cycles in which exactly one of the two flip-flops was set. The lock rule uses two thresholds. A wide error clears the channel's lock at once. Lock returns only after a run of consecutive narrow comparisons. A park input per channel forces that channel's command to high impedance, holds its detector and lock state at zero, and counts the channel as locked. The single lock output is high only when every channel is locked or parked.

Top module: `pfd_lock_pair`

## Requirements
- R1: With the sense bit at 1, a reference strobe that leads the feedback strobe by k cycles makes the command source (01) for k cycles, then balanced (11) for one cycle, then off (00). A feedback strobe that leads gives sink (10) in place of source. The command for channel i is on bits [2i+1:2i].
- R2: With the sense bit at 0, source and sink swap. A leading reference gives sink (10) and a leading feedback gives source (01).
- R3: Reference and feedback strobes in the same cycle give exactly one balanced (11) cycle and then off (00), with no source or sink cycle.
- R4: A second strobe of the same kind, arriving while that kind is already pending, has no effect. The command stays source until the opposite strobe arrives, which keeps the detection range to one period in either direction.
- R5: A channel becomes locked after LOCK_CNT (default 3) consecutive comparisons whose width is at most LOCK_W (default 1) cycles. The lock output reflects this from the cycle after the comparison's balanced cycle.
- R6: A comparison whose width is at least UNLK_W (default 3) cycles clears that channel's lock and its run count.
- R7: A comparison whose width lies strictly between LOCK_W and UNLK_W restarts the run count but leaves the channel's current lock state as it is.
- R8: The lock output is the AND, over all channels, of (channel locked OR channel parked).
- R9: While a channel is parked, its command is off (00), strobes on that channel have no effect, and the channel counts as locked.
- R10: On leaving park, the channel starts with both detector flip-flops clear and lock cleared. It needs a fresh run of LOCK_CNT narrow comparisons before it locks.
- R11: After reset, every command is off (00) and the lock output is low when no channel is parked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; all state and width counting use it |
| rst | input | 1 | Synchronous active-high reset |
| ref_stb | input | NCH | Per-channel single-cycle reference edge strobe |
| fb_stb | input | NCH | Per-channel single-cycle feedback edge strobe |
| pol | input | NCH | Per-channel sense bit; 1 means a leading reference sources |
| pwr_save | input | NCH | Per-channel park request, active high |
| pump_cmd | output | 2*NCH | Per-channel command: 00 off, 01 source, 10 sink, 11 balanced |
| lock_out | output | 1 | High when every channel is locked or parked |

## Verification
Some rules are checked on every cycle. A parked channel always shows off. A channel leaving park starts from off. With the sense bit held, the command never flips straight between source and sink. A balanced cycle lasts one cycle unless new coincident strobes arrive. The lock output is high whenever all channels are parked. The lock hysteresis (R5 to R7) depends on a history of measured widths, so only the bench scenarios can show it. The same holds for the exact pulse lengths, ignoring a repeated strobe, and the per-channel lock combination after one channel leaves park.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        PUMP_OFF = 2'b00,
        PUMP_SRC = 2'b01,
        PUMP_SNK = 2'b10,
        PUMP_BAL = 2'b11
    } pump_e;

    typedef enum logic [1:0] {
        ERR_NARROW = 2'b00,
        ERR_MIDDLE = 2'b01,
        ERR_WIDE   = 2'b10
    } err_class_e;

    typedef struct packed {
        logic lead;  // reference edge pending
        logic lag;   // feedback edge pending
    } pfd_state_t;

    function automatic pump_e pump_encode(input pfd_state_t s, input logic sense,
                                          input logic park);
        pump_e r;
        r = PUMP_OFF;
        if (!park) begin
            case ({s.lead, s.lag})
                2'b11:   r = PUMP_BAL;
                2'b10:   r = sense ? PUMP_SRC : PUMP_SNK;
                2'b01:   r = sense ? PUMP_SNK : PUMP_SRC;
                default: r = PUMP_OFF;
            endcase
        end
        return r;
    endfunction

    function automatic err_class_e err_classify(input int unsigned width,
                                                input int unsigned narrow_max,
                                                input int unsigned wide_min);
        err_class_e c;
        if (width >= wide_min)
            c = ERR_WIDE;
        else if (width <= narrow_max)
            c = ERR_NARROW;
        else
            c = ERR_MIDDLE;
        return c;
    endfunction

endpackage

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       park,
    input  logic       ref_stb,
    input  logic       fb_stb,
    output pfd_state_t st,
    output logic       cmp_done,
    output logic       pending
);

    assign cmp_done = st.lead & st.lag;
    assign pending  = st.lead ^ st.lag;

    always_ff @(posedge clk) begin
        if (rst || park) begin
            st <= '0;
        end else if (cmp_done) begin
            // both set: end of comparison, a fresh strobe may start the next one
            st.lead <= ref_stb;
            st.lag  <= fb_stb;
        end else begin
            st.lead <= st.lead | ref_stb;
            st.lag  <= st.lag  | fb_stb;
        end
    end

endmodule

// File: rtl/pfd_lockdet.sv
module pfd_lockdet
    import pfd_pkg::*;
#(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned LOCK_W   = 1,
    parameter int unsigned UNLK_W   = 3,
    parameter int unsigned LOCK_CNT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic park,
    input  logic pending,
    input  logic cmp_done,
    output logic locked
);

    localparam int unsigned RUN_W = $clog2(LOCK_CNT + 1);
    localparam logic [CNT_W-1:0] WIDTH_MAX = '1;
    localparam logic [RUN_W-1:0] RUN_TOP   = RUN_W'(LOCK_CNT);

    logic [CNT_W-1:0] width_q;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_inc;
    err_class_e       cls;

    assign cls     = err_classify(int'(width_q), LOCK_W, UNLK_W);
    assign run_inc = (run_q == RUN_TOP) ? run_q : run_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || park || cmp_done)
            width_q <= '0;
        else if (pending && width_q != WIDTH_MAX)
            width_q <= width_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || park) begin
            run_q  <= '0;
            locked <= 1'b0;
        end else if (cmp_done) begin
            unique case (cls)
                ERR_WIDE: begin
                    run_q  <= '0;
                    locked <= 1'b0;
                end
                ERR_NARROW: begin
                    run_q <= run_inc;
                    if (run_inc >= RUN_TOP)
                        locked <= 1'b1;
                end
                default: run_q <= '0;
            endcase
        end
    end

endmodule

// File: rtl/pfd_channel.sv
module pfd_channel
    import pfd_pkg::*;
#(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned LOCK_W   = 1,
    parameter int unsigned UNLK_W   = 3,
    parameter int unsigned LOCK_CNT = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       park,
    input  logic       sense,
    input  logic       ref_stb,
    input  logic       fb_stb,
    output logic [1:0] cmd,
    output logic       chan_ok
);

    pfd_state_t st;
    logic       cmp_done;
    logic       pending;
    logic       locked;
    pump_e      code;

    pfd_core u_core (
        .clk      (clk),
        .rst      (rst),
        .park     (park),
        .ref_stb  (ref_stb),
        .fb_stb   (fb_stb),
        .st       (st),
        .cmp_done (cmp_done),
        .pending  (pending)
    );

    pfd_lockdet #(
        .CNT_W    (CNT_W),
        .LOCK_W   (LOCK_W),
        .UNLK_W   (UNLK_W),
        .LOCK_CNT (LOCK_CNT)
    ) u_lock (
        .clk      (clk),
        .rst      (rst),
        .park     (park),
        .pending  (pending),
        .cmp_done (cmp_done),
        .locked   (locked)
    );

    assign code    = pump_encode(st, sense, park);
    assign cmd     = code;
    assign chan_ok = park | locked;

endmodule

// File: rtl/pfd_lock_pair.sv
module pfd_lock_pair #(
    parameter int unsigned NCH      = 2,
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned LOCK_W   = 1,
    parameter int unsigned UNLK_W   = 3,
    parameter int unsigned LOCK_CNT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   ref_stb,
    input  logic [NCH-1:0]   fb_stb,
    input  logic [NCH-1:0]   pol,
    input  logic [NCH-1:0]   pwr_save,
    output logic [2*NCH-1:0] pump_cmd,
    output logic             lock_out
);

    logic [NCH-1:0] ok;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pfd_channel #(
            .CNT_W    (CNT_W),
            .LOCK_W   (LOCK_W),
            .UNLK_W   (UNLK_W),
            .LOCK_CNT (LOCK_CNT)
        ) u_chan (
            .clk     (clk),
            .rst     (rst),
            .park    (pwr_save[i]),
            .sense   (pol[i]),
            .ref_stb (ref_stb[i]),
            .fb_stb  (fb_stb[i]),
            .cmd     (pump_cmd[2*i +: 2]),
            .chan_ok (ok[i])
        );
    end

    assign lock_out = &ok;

endmodule

// File: rtl/pfd_lock_pair_chk.sv
module pfd_lock_pair_chk #(
    parameter int unsigned NCH = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [NCH-1:0]   ref_stb,
    input logic [NCH-1:0]   fb_stb,
    input logic [NCH-1:0]   pol,
    input logic [NCH-1:0]   pwr_save,
    input logic [2*NCH-1:0] pump_cmd,
    input logic             lock_out
);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        AST_PARK_OFF: assert property (@(posedge clk) disable iff (rst)
            pwr_save[i] |-> pump_cmd[2*i +: 2] == 2'b00);  // R9

        AST_UNPARK_CLEAN: assert property (@(posedge clk) disable iff (rst)
            $fell(pwr_save[i]) |-> pump_cmd[2*i +: 2] == 2'b00);  // R10

        AST_NO_SRC_TO_SNK: assert property (@(posedge clk) disable iff (rst)
            ($past(pump_cmd[2*i +: 2]) == 2'b01 && $stable(pol[i]))
                |-> pump_cmd[2*i +: 2] != 2'b10);  // R1

        AST_NO_SNK_TO_SRC: assert property (@(posedge clk) disable iff (rst)
            ($past(pump_cmd[2*i +: 2]) == 2'b10 && $stable(pol[i]))
                |-> pump_cmd[2*i +: 2] != 2'b01);  // R2

        AST_BAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
            (pump_cmd[2*i +: 2] == 2'b11 && !(ref_stb[i] && fb_stb[i]))
                |=> pump_cmd[2*i +: 2] != 2'b11);  // R3
    end

    AST_ALL_PARKED_LOCK: assert property (@(posedge clk) disable iff (rst)
        (&pwr_save) |-> lock_out);  // R8

endmodule

bind pfd_lock_pair pfd_lock_pair_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ref_stb  (ref_stb),
    .fb_stb   (fb_stb),
    .pol      (pol),
    .pwr_save (pwr_save),
    .pump_cmd (pump_cmd),
    .lock_out (lock_out)
);

// File: tb/sim_pfd_lock_pair.sv
module sim_pfd_lock_pair;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ref_stb  = '0;
    logic [1:0] fb_stb   = '0;
    logic [1:0] pol      = 2'b11;
    logic [1:0] pwr_save = 2'b00;
    logic [3:0] pump_cmd;
    logic       lock_out;

    always #10 clk = ~clk;  // 50 MHz

    pfd_lock_pair u0 (
        .clk      (clk),
        .rst      (rst),
        .ref_stb  (ref_stb),
        .fb_stb   (fb_stb),
        .pol      (pol),
        .pwr_save (pwr_save),
        .pump_cmd (pump_cmd),
        .lock_out (lock_out)
    );

    typedef struct {
        int         ch;
        logic [1:0] cmd;
        logic       lk;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;
    bit   exp_lk[2];
    int   run[2];

    // expected lock model from R5..R8
    function automatic logic want_lock();
        return (exp_lk[0] | pwr_save[0]) & (exp_lk[1] | pwr_save[1]);
    endfunction

    task automatic judge(input int ch, input int k);
        int w;
        w = (k < 0) ? -k : k;
        if (w >= 3) begin
            exp_lk[ch] = 0;
            run[ch]    = 0;
        end else if (w <= 1) begin
            run[ch] = run[ch] + 1;
            if (run[ch] >= 3) exp_lk[ch] = 1;
        end else begin
            run[ch] = 0;
        end
    endtask

    task automatic cyc(input int ch, input bit r, input bit f,
                       input logic [1:0] cmd, input string tag);
        exp_t e;
        @(negedge clk);
        ref_stb = '0;
        fb_stb  = '0;
        ref_stb[ch] = r;
        fb_stb[ch]  = f;
        e.ch  = ch;
        e.cmd = cmd;
        e.lk  = want_lock();
        e.tag = tag;
        q.push_back(e);
    endtask

    // ref leads by k cycles when k>0, feedback leads when k<0
    task automatic compare(input int ch, input int k, input string tag);
        logic [1:0] c;
        if (k > 0) c = pol[ch] ? 2'b01 : 2'b10;
        else       c = pol[ch] ? 2'b10 : 2'b01;
        if (k == 0) begin
            cyc(ch, 1, 1, 2'b11, tag);
        end else if (k > 0) begin
            cyc(ch, 1, 0, c, tag);
            repeat (k - 1) cyc(ch, 0, 0, c, tag);
            cyc(ch, 0, 1, 2'b11, tag);
        end else begin
            cyc(ch, 0, 1, c, tag);
            repeat (-k - 1) cyc(ch, 0, 0, c, tag);
            cyc(ch, 1, 0, 2'b11, tag);
        end
        judge(ch, k);
        cyc(ch, 0, 0, 2'b00, tag);
        cyc(ch, 0, 0, 2'b00, tag);
    endtask

    task automatic set_park(input int ch, input bit v);
        @(negedge clk);
        ref_stb = '0;
        fb_stb  = '0;
        pwr_save[ch] = v;
        exp_lk[ch] = 0;
        run[ch]    = 0;
    endtask

    task automatic set_pol(input int ch, input bit v);
        @(negedge clk);
        ref_stb = '0;
        fb_stb  = '0;
        pol[ch] = v;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // monitor: pops one expectation per cycle after the active edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (pump_cmd[2*e.ch +: 2] !== e.cmd || lock_out !== e.lk) begin
                    errors++;
                    $display("FAIL %s ch%0d cmd=%0d lock=%0d expected cmd=%0d lock=%0d",
                             e.tag, e.ch, pump_cmd[2*e.ch +: 2], lock_out, e.cmd, e.lk);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        exp_lk[0] = 0; exp_lk[1] = 0; run[0] = 0; run[1] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cyc(0, 0, 0, 2'b00, "R11 reset state");

        set_park(1, 1);
        compare(0, 1, "R1 R5 narrow 1 of 3");
        compare(0, 1, "R5 narrow 2 of 3");
        compare(0, 1, "R5 narrow 3 of 3 lock");
        compare(0, 3, "R6 wide error unlocks");
        compare(0, 1, "R7 run a");
        compare(0, 1, "R7 run b");
        compare(0, 2, "R7 middle restarts run");
        compare(0, 1, "R7 run c");
        compare(0, 1, "R7 run d still unlocked");
        compare(0, 0, "R3 R5 coincident relock");
        compare(0, -2, "R1 R7 feedback leads sink, lock held");
        compare(0, -1, "R1 feedback leads by one");

        set_pol(0, 0);
        compare(0, 1, "R2 ref leads sinks");
        compare(0, -1, "R2 feedback leads sources");
        set_pol(0, 1);

        cyc(0, 1, 0, 2'b01, "R4 first ref");
        cyc(0, 1, 0, 2'b01, "R4 second ref ignored");
        cyc(0, 0, 1, 2'b11, "R4 feedback ends");
        judge(0, 2);
        cyc(0, 0, 0, 2'b00, "R4 off after");

        set_park(1, 0);
        cyc(1, 0, 0, 2'b00, "R8 channel 1 unparked drops lock");
        compare(1, 1, "R8 ch1 narrow a");
        compare(1, 0, "R8 ch1 narrow b");
        compare(1, -1, "R8 ch1 narrow c both locked");
        set_pol(1, 0);
        compare(1, 1, "R2 ch1 ref leads sinks");

        set_park(0, 1);
        cyc(0, 1, 0, 2'b00, "R9 parked off, ref ignored");
        cyc(0, 0, 1, 2'b00, "R9 parked off, fb ignored");
        cyc(0, 1, 1, 2'b00, "R9 parked counts locked");
        set_park(0, 0);
        cyc(0, 0, 0, 2'b00, "R10 unpark clean, lock low");
        compare(0, 1, "R10 relock a");
        compare(0, 1, "R10 relock b");
        compare(0, 1, "R10 relock c");

        @(negedge clk);
        wait (q.size() == 0);
        #20;
        done = 1;
        summary();
        $finish;
    end

endmodule